// File: doc/BRIEF.md
# Chirp and Keyed-Frequency Sweep Controller

This block generates the control words for a downstream sine/cosine oscillator: an 18-bit phase increment and a 16-bit amplitude. It has three sweep modes. A linear chirp raises the increment by a programmable step each time a clock divider expires. A logarithmic sweep moves a single set bit one place toward the top, so each divider period doubles the frequency. A keyed mode selects between two programmed increments with a data bit, in the same cycle, so the oscillator's phase stays continuous.

The amplitude comes from a small constant gain table. The upper bits of the increment being output address this table, which lets the user correct for a frequency-dependent gain later in the signal path. A start pulse latches the mode and reloads the first increment. In the linear and logarithmic modes, reaching the end of the sweep raises a one-cycle done pulse. A wrap flag then chooses between restarting the sweep and halting on the final value.

Top module: `chirp_sweep_ctrl`

## Requirements
- R1: While reset is held and after it is released, inc_out is 0, done is 0 and amp_out is 0x4000. No sweep runs until the first start.
- R2: A start pulse latches mode_sel and reloads the increment on that same clock edge. The mode codes are 0 linear, 1 logarithmic, 2 keyed and 3 linear. Linear reloads inc_init. Logarithmic reloads a single 1 at bit position log_pos.
- R3: While a linear or logarithmic sweep runs, the increment updates once every div_limit+1 cycles. The first update comes div_limit+1 edges after the start edge.
- R4: In linear mode, each update adds step to the increment.
- R5: In linear mode, an update whose sum reaches inc_end or overflows raises done for exactly one cycle. With wrap=0 the increment becomes inc_end and the sweep halts. With wrap=1 the increment reloads inc_init and the sweep continues.
- R6: In logarithmic mode, each update shifts the increment left by one. An update that finds bit 17 set raises done for one cycle. With wrap=1 the increment reloads the seed bit. With wrap=0 the increment holds at its current value and the sweep halts.
- R7: In keyed mode, inc_out equals fsk_mark when fsk_bit is 1 and fsk_space when fsk_bit is 0, in the same cycle the bit changes, and done stays 0.
- R8: amp_out equals 0x4000 + 0x0400 × inc_out[17:14], in the same cycle as inc_out.
- R9: After a sweep halts, inc_out holds its value and ignores later changes to step and inc_end until the next start.
- R10: A start during a running sweep restarts it from the initial increment and restarts the divider period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Latch mode and reload the first increment |
| mode_sel | input | 2 | Sweep mode code |
| wrap | input | 1 | 1: restart at end of sweep; 0: halt |
| div_limit | input | 16 | Divider terminal count; period is div_limit+1 cycles |
| step | input | 18 | Linear step added per update |
| inc_init | input | 18 | First increment of a linear sweep |
| inc_end | input | 18 | End value of a linear sweep |
| log_pos | input | 5 | Seed bit position for the logarithmic sweep |
| fsk_bit | input | 1 | Keyed-mode data bit |
| fsk_mark | input | 18 | Increment used when fsk_bit is 1 |
| fsk_space | input | 18 | Increment used when fsk_bit is 0 |
| inc_out | output | 18 | Phase increment to the oscillator |
| amp_out | output | 16 | Gain-compensation amplitude |
| done | output | 1 | One-cycle pulse at the end of a sweep |

## Verification
Some internal faults appear at the ports only after a delay. A wrong divider count shows up as an increment update arriving one or more cycles early or late, visible within the first div_limit+1 cycles after start. A wrong end comparison or wrap decision shows up on the edge where the sweep ends: the increment lands on the wrong value, or done is missing or lasts too long. Other faults appear in the same cycle. A wrong latched mode or keyed select corrupts inc_out immediately, and a gain-table error appears in amp_out in the same cycle as the increment that addresses it.

// File: rtl/chirp_pkg.sv
package chirp_pkg;
    typedef enum logic [1:0] {
        SWP_LINEAR = 2'd0,
        SWP_LOG    = 2'd1,
        SWP_KEYED  = 2'd2,
        SWP_ALTLIN = 2'd3
    } sweep_mode_e;

    localparam int unsigned GAIN_BASE  = 32'h4000;
    localparam int unsigned GAIN_SLOPE = 32'h0400;
endpackage

// File: rtl/sweep_divider.sv
module sweep_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign tick = en && !clr && (cnt_q == limit);

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (en)
            cnt_d = (cnt_q == limit) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && limit != '0 && $stable(limit)) |=> !tick);
endmodule

// File: rtl/gain_lut.sv
module gain_lut #(
    parameter int INC_W = 18,
    parameter int AMP_W = 16,
    parameter int ADR_W = 4
) (
    input  logic [INC_W-1:0] inc,
    output logic [AMP_W-1:0] amp
);
    import chirp_pkg::*;
    localparam int DEPTH = 1 << ADR_W;

    logic [AMP_W-1:0] table_w [DEPTH];
    logic [ADR_W-1:0] adr;

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        assign table_w[gi] = AMP_W'(GAIN_BASE + gi * GAIN_SLOPE);
    end

    assign adr = inc[INC_W-1 -: ADR_W];
    assign amp = table_w[adr];
endmodule

// File: rtl/chirp_sweep_ctrl.sv
module chirp_sweep_ctrl
    import chirp_pkg::*;
#(
    parameter int INC_W = 18,
    parameter int AMP_W = 16,
    parameter int DIV_W = 16,
    parameter int ADR_W = 4,
    localparam int POS_W = $clog2(INC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       mode_sel,
    input  logic             wrap,
    input  logic [DIV_W-1:0] div_limit,
    input  logic [INC_W-1:0] step,
    input  logic [INC_W-1:0] inc_init,
    input  logic [INC_W-1:0] inc_end,
    input  logic [POS_W-1:0] log_pos,
    input  logic             fsk_bit,
    input  logic [INC_W-1:0] fsk_mark,
    input  logic [INC_W-1:0] fsk_space,
    output logic [INC_W-1:0] inc_out,
    output logic [AMP_W-1:0] amp_out,
    output logic             done
);
    typedef struct packed {
        logic [INC_W-1:0] inc;
        logic             running;
        logic             done;
        sweep_mode_e      mode;
    } state_t;

    state_t st_d, st_q;
    logic             tick;
    logic [INC_W:0]   sum;
    logic             hit_end;
    logic [INC_W-1:0] log_seed;
    sweep_mode_e      mode_in;

    assign mode_in  = sweep_mode_e'(mode_sel);
    assign sum      = {1'b0, st_q.inc} + {1'b0, step};
    assign hit_end  = (sum >= {1'b0, inc_end});
    assign log_seed = (int'(log_pos) < INC_W) ? (INC_W'(1) << log_pos) : '0;

    sweep_divider #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (start),
        .en   (st_q.running && st_q.mode != SWP_KEYED),
        .limit(div_limit),
        .tick (tick)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start) begin
            st_d.mode    = mode_in;
            st_d.running = 1'b1;
            case (mode_in)
                SWP_LOG:   st_d.inc = log_seed;
                SWP_KEYED: st_d.inc = '0;
                default:   st_d.inc = inc_init;
            endcase
        end else if (st_q.running && tick) begin
            case (st_q.mode)
                SWP_LOG: begin
                    if (st_q.inc[INC_W-1]) begin
                        st_d.done = 1'b1;
                        if (wrap) st_d.inc     = log_seed;
                        else      st_d.running = 1'b0;
                    end else begin
                        st_d.inc = st_q.inc << 1;
                    end
                end
                SWP_KEYED: ;
                default: begin
                    if (hit_end) begin
                        st_d.done = 1'b1;
                        if (wrap) begin
                            st_d.inc = inc_init;
                        end else begin
                            st_d.inc     = inc_end;
                            st_d.running = 1'b0;
                        end
                    end else begin
                        st_d.inc = sum[INC_W-1:0];
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.inc     <= '0;
            st_q.running <= 1'b0;
            st_q.done    <= 1'b0;
            st_q.mode    <= SWP_LINEAR;
        end else begin
            st_q <= st_d;
        end
    end

    assign inc_out = (st_q.mode == SWP_KEYED) ? (fsk_bit ? fsk_mark : fsk_space) : st_q.inc;
    assign done    = st_q.done;

    gain_lut #(.INC_W(INC_W), .AMP_W(AMP_W), .ADR_W(ADR_W)) u_lut (
        .inc(inc_out),
        .amp(amp_out)
    );

    // R5
    done_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(st_q.running));

    // R7
    keyed_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(st_q.mode) != SWP_KEYED);

    // R9
    halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.running && !start) |=> $stable(st_q.inc));

    // R2
    start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st_q.running && !done));
endmodule

// File: tb/chirp_sweep_ctrl_bench.sv
`timescale 1ns/1ps
module chirp_sweep_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [1:0]  mode_sel;
    logic        wrap;
    logic [15:0] div_limit;
    logic [17:0] step, inc_init, inc_end;
    logic [4:0]  log_pos;
    logic        fsk_bit;
    logic [17:0] fsk_mark, fsk_space;
    logic [17:0] inc_out;
    logic [15:0] amp_out;
    logic        done;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    chirp_sweep_ctrl u_chirp_sweep_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_sel(mode_sel), .wrap(wrap),
        .div_limit(div_limit), .step(step), .inc_init(inc_init), .inc_end(inc_end),
        .log_pos(log_pos), .fsk_bit(fsk_bit), .fsk_mark(fsk_mark), .fsk_space(fsk_space),
        .inc_out(inc_out), .amp_out(amp_out), .done(done)
    );

    typedef struct packed {
        logic        b;
        logic [17:0] mark;
        logic [17:0] space;
        logic [17:0] exp_inc;
        logic [15:0] exp_amp;
    } kvec_t;

    localparam kvec_t KEYED_VECS [6] = '{
        '{1'b1, 18'h04000, 18'h00100, 18'h04000, 16'h4400},
        '{1'b0, 18'h04000, 18'h00100, 18'h00100, 16'h4000},
        '{1'b1, 18'h3FFFF, 18'h00000, 18'h3FFFF, 16'h7C00},
        '{1'b0, 18'h3FFFF, 18'h2C000, 18'h2C000, 16'h6C00},
        '{1'b1, 18'h1C000, 18'h00000, 18'h1C000, 16'h5C00},
        '{1'b0, 18'h00000, 18'h24001, 18'h24001, 16'h6400}
    };

    function automatic logic [15:0] amp_of(input logic [17:0] inc);
        return 16'h4000 + 16'h0400 * inc[17:14];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic adv(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_start(input logic [1:0] m);
        mode_sel = m;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; mode_sel = 2'd0; wrap = 1'b0;
        div_limit = 16'd2; step = 18'h00100; inc_init = 18'h01000; inc_end = 18'h01400;
        log_pos = 5'd15; fsk_bit = 1'b0; fsk_mark = '0; fsk_space = '0;
        adv(3);
        chk("R1 inc in reset", inc_out, 0);
        chk("R1 done in reset", done, 0);
        chk("R1 amp in reset", amp_out, 16'h4000);
        rst_n = 1'b1;
        adv(4);
        chk("R1 idle after reset", inc_out, 0);

        // Linear, no wrap: R2 R3 R4 R5 R9
        pulse_start(2'd0);
        chk("R2 linear load", inc_out, 18'h01000);
        adv(2);
        chk("R3 no early update", inc_out, 18'h01000);
        adv(1);
        chk("R4 first step", inc_out, 18'h01100);
        chk("R8 amp linear", amp_out, amp_of(18'h01100));
        adv(6);
        chk("R4 third step", inc_out, 18'h01300);
        chk("R5 no done before end", done, 0);
        adv(3);
        chk("R5 end value no wrap", inc_out, 18'h01400);
        chk("R5 done pulse", done, 1);
        adv(1);
        chk("R5 done one cycle", done, 0);
        step = 18'h00777; inc_end = 18'h3FFFF;
        adv(10);
        chk("R9 halted holds", inc_out, 18'h01400);
        chk("R9 no done when halted", done, 0);
        step = 18'h00100; inc_end = 18'h01400;

        // Linear with wrap: R5
        wrap = 1'b1;
        pulse_start(2'd3);
        chk("R2 code3 linear", inc_out, 18'h01000);
        adv(12);
        chk("R5 wrap reload", inc_out, 18'h01000);
        chk("R5 wrap done", done, 1);
        adv(3);
        chk("R5 continues after wrap", inc_out, 18'h01100);

        // Restart mid-run: R10
        pulse_start(2'd0);
        chk("R10 restart value", inc_out, 18'h01000);
        adv(2);
        chk("R10 divider restarted", inc_out, 18'h01000);
        adv(1);
        chk("R10 step after restart", inc_out, 18'h01100);

        // Logarithmic with wrap: R6 R8
        div_limit = 16'd0; log_pos = 5'd15;
        pulse_start(2'd1);
        chk("R2 log seed", inc_out, 18'h08000);
        chk("R8 amp seed", amp_out, 16'h4800);
        adv(1);
        chk("R6 shift 1", inc_out, 18'h10000);
        chk("R8 amp shift 1", amp_out, 16'h5000);
        adv(1);
        chk("R6 shift 2", inc_out, 18'h20000);
        chk("R8 amp top", amp_out, 16'h6000);
        adv(1);
        chk("R6 wrap reseed", inc_out, 18'h08000);
        chk("R6 log done", done, 1);

        // Logarithmic, no wrap
        wrap = 1'b0; log_pos = 5'd16;
        pulse_start(2'd1);
        chk("R2 log seed 16", inc_out, 18'h10000);
        adv(2);
        chk("R6 halt value", inc_out, 18'h20000);
        chk("R6 halt done", done, 1);
        adv(1);
        chk("R6 halted hold", inc_out, 18'h20000);
        chk("R6 done cleared", done, 0);

        // Keyed mode table: R7 R8
        pulse_start(2'd2);
        for (int i = 0; i < 6; i++) begin
            fsk_bit = KEYED_VECS[i].b;
            fsk_mark = KEYED_VECS[i].mark;
            fsk_space = KEYED_VECS[i].space;
            #1;
            chk("R7 keyed same cycle", inc_out, KEYED_VECS[i].exp_inc);
            chk("R8 keyed amp", amp_out, KEYED_VECS[i].exp_amp);
            adv(1);
            chk("R7 keyed no done", done, 0);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule